// File: doc/BRIEF.md
# Instruction Cache Way Parity Checker

This block checks the stored parity of one way of an instruction cache line. A caller presents the way's tag words together with a start pulse. It then feeds the way's data beats, one at a time, over a valid strobe. Each beat is a side word plus two 32-bit instructions. The block checks the tag in the start cycle and keeps the result. It checks every beat as it arrives and keeps a running data-error flag. After the last beat it pulses a done strobe. Both flags stay readable until the next start.

All parity in this block is even: a stored parity bit equals the XOR of the bits it covers. The tag carries a valid bit with its own parity copy, plus two parity bits, each over a separate field of the low tag word. Each beat carries one parity bit over eight predecode bits and one parity bit per byte of each instruction. Error scrubbing, tag storage and refill are outside the block.

Top module: `icache_parity_chk`

## Requirements
- R1: A tag error is reported when tag-high bit 29 (valid) differs from tag-high bit 27 (its parity copy), whether or not the line is valid.
- R2: With bit 29 set, a tag error is reported when tag-low bit 10 differs from the XOR of tag-low bits 23:0 with bits 11 and 10 excluded.
- R3: With bit 29 set, a tag error is reported when tag-low bit 11 differs from the XOR of tag-low bits 63:24.
- R4: With bit 29 clear, mismatches of tag-low bits 10 and 11 produce no tag error.
- R5: A beat is in error when side-word bit 16 differs from the XOR of side-word bits 15:8 (predecode bits).
- R6: A beat is in error when side-word bits 7:4 differ from the byte parities of instruction A. Bit 4+k is the XOR of instruction bits 8k+7:8k, so the most significant byte maps to bit 7.
- R7: A beat is in error when side-word bits 3:0 differ from the byte parities of instruction B. Bit k is the XOR of instruction bits 8k+7:8k.
- R8: The data-error flag is the OR over all four beats of a way, so an error on any beat stays set. A start clears it. Side-word bits 23:17 have no effect.
- R9: Busy rises in the cycle after an accepted start. Idle cycles between beats are allowed. Done is high for exactly one cycle, in the cycle after the fourth accepted beat, and busy falls in that same cycle.
- R10: A start while busy is ignored, and a beat strobe while idle is ignored.
- R11: After reset, busy, done and both error flags are low.
- R12: Between done and the next accepted start, both error flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin checking a way; the tag is sampled in this cycle |
| tag_hi_i | input | 32 | Upper tag word (valid bit and its parity) |
| tag_lo_i | input | 64 | Lower tag word (address tag and two parity bits) |
| beat_valid_i | input | 1 | The beat inputs carry a beat this cycle |
| side_i | input | 24 | Beat side word: predecode, its parity, instruction byte parities |
| insn_a_i | input | 32 | First instruction of the beat |
| insn_b_i | input | 32 | Second instruction of the beat |
| busy_o | output | 1 | Beats of the current way are still expected |
| done_o | output | 1 | One-cycle pulse: the way's results are final |
| tag_err_o | output | 1 | Tag parity error for the last checked way |
| data_err_o | output | 1 | Data parity error on any beat of the last checked way |

## Verification
The assertions take two things for granted about the caller. Start is given only while the block is idle, and beat strobes arrive only while it is busy. Inputs are known at every clock edge once reset is released. The stimulus respects this: each way starts from idle, supplies exactly four strobed beats, and may leave idle gaps between them. The only exceptions are the deliberate out-of-phase strobes that check R10. These do not break any assertion, because the properties are stated in terms of accepted starts and accepted beats.

// File: rtl/icp_pkg.sv
package icp_pkg;
  // Tag-high field positions
  localparam int unsigned VLD_POS     = 29;
  localparam int unsigned VLD_PAR_POS = 27;
  // Tag-low parity positions and covered field split
  localparam int unsigned LO_PAR0_POS = 10;
  localparam int unsigned LO_PAR1_POS = 11;
  localparam int unsigned LO_SPLIT    = 24;
  // Side word layout
  localparam int unsigned PRE_LSB     = 8;
  localparam int unsigned PRE_W       = 8;
  localparam int unsigned PRE_PAR_POS = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/icp_tag_check.sv
module icp_tag_check
  import icp_pkg::*;
#(
  parameter int unsigned LO_W = 64
) (
  input  logic            vld_i,
  input  logic            vld_par_i,
  input  logic [LO_W-1:0] tag_lo_i,
  output logic            fault_o
);
  localparam int unsigned HI_FIELD_W = LO_W - LO_SPLIT;

  logic [LO_SPLIT-1:0]   low_field;
  logic [HI_FIELD_W-1:0] high_field;
  logic                  low_bad;
  logic                  high_bad;

  always_comb begin
    low_field              = tag_lo_i[LO_SPLIT-1:0];
    low_field[LO_PAR0_POS] = 1'b0;
    low_field[LO_PAR1_POS] = 1'b0;
    high_field             = tag_lo_i[LO_W-1:LO_SPLIT];
    low_bad  = (^low_field)  ^ tag_lo_i[LO_PAR0_POS];
    high_bad = (^high_field) ^ tag_lo_i[LO_PAR1_POS];
    fault_o  = (vld_i ^ vld_par_i) | (vld_i & (low_bad | high_bad));
  end
endmodule

// File: rtl/icp_beat_check.sv
module icp_beat_check
  import icp_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned SIDE_W = 24
) (
  input  logic [SIDE_W-1:0] side_i,
  input  logic [INSN_W-1:0] insn_a_i,
  input  logic [INSN_W-1:0] insn_b_i,
  output logic              fault_o
);
  localparam int unsigned NBYTES = INSN_W / 8;
  localparam int unsigned NINSN  = 2;

  logic [NINSN-1:0][INSN_W-1:0] insn;
  logic [NINSN-1:0][NBYTES-1:0] calc_par;
  logic [NINSN-1:0]             insn_bad;
  logic                         pre_bad;

  // Index 1 is instruction A (upper nibble), index 0 is B (lower nibble)
  assign insn[1] = insn_a_i;
  assign insn[0] = insn_b_i;

  for (genvar i = 0; i < NINSN; i++) begin : g_insn
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      assign calc_par[i][k] = ^insn[i][8*k +: 8];
    end
    assign insn_bad[i] = |(calc_par[i] ^ side_i[NBYTES*i +: NBYTES]);
  end

  assign pre_bad = (^side_i[PRE_LSB +: PRE_W]) ^ side_i[PRE_PAR_POS];
  assign fault_o = pre_bad | (|insn_bad);
endmodule

// File: rtl/icp_way_seq.sv
module icp_way_seq
  import icp_pkg::*;
#(
  parameter int unsigned N_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic beat_valid_i,
  input  logic tag_fault_i,
  input  logic beat_fault_i,
  output logic busy_o,
  output logic done_o,
  output logic tag_err_o,
  output logic data_err_o
);
  localparam int unsigned CNT_W = (N_BEATS > 1) ? $clog2(N_BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BEATS - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             terr_q, terr_d;
  logic             derr_q, derr_d;
  logic             start_ok, beat_ok, upd_en;

  assign start_ok = start_i & (st_q == ST_IDLE);
  assign beat_ok  = beat_valid_i & (st_q == ST_RUN);
  assign upd_en   = start_ok | beat_ok | done_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    terr_d = terr_q;
    derr_d = derr_q;
    done_d = 1'b0;
    if (start_ok) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      terr_d = tag_fault_i;
      derr_d = 1'b0;
    end else if (beat_ok) begin
      derr_d = derr_q | beat_fault_i;
      if (cnt_q == LAST) begin
        st_d   = ST_IDLE;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      terr_q <= 1'b0;
      derr_q <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      terr_q <= terr_d;
      derr_q <= derr_d;
    end
  end

  assign busy_o     = (st_q == ST_RUN);
  assign done_o     = done_q;
  assign tag_err_o  = terr_q;
  assign data_err_o = derr_q;
endmodule

// File: rtl/icache_parity_chk.sv
module icache_parity_chk
  import icp_pkg::*;
#(
  parameter int unsigned N_BEATS = 4,
  parameter int unsigned HI_W    = 32,
  parameter int unsigned LO_W    = 64,
  parameter int unsigned SIDE_W  = 24,
  parameter int unsigned INSN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HI_W-1:0]   tag_hi_i,
  input  logic [LO_W-1:0]   tag_lo_i,
  input  logic              beat_valid_i,
  input  logic [SIDE_W-1:0] side_i,
  input  logic [INSN_W-1:0] insn_a_i,
  input  logic [INSN_W-1:0] insn_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tag_err_o,
  output logic              data_err_o
);
  logic tag_fault;
  logic beat_fault;
  logic unused_hi;

  // Only the valid bit and its parity copy matter in the upper tag word
  assign unused_hi = ^{tag_hi_i[HI_W-1:VLD_POS+1], tag_hi_i[VLD_POS-1:VLD_PAR_POS+1],
                       tag_hi_i[VLD_PAR_POS-1:0]};

  icp_tag_check #(.LO_W(LO_W)) u_tag (
    .vld_i     (tag_hi_i[VLD_POS]),
    .vld_par_i (tag_hi_i[VLD_PAR_POS]),
    .tag_lo_i  (tag_lo_i),
    .fault_o   (tag_fault)
  );

  icp_beat_check #(.INSN_W(INSN_W), .SIDE_W(SIDE_W)) u_beat (
    .side_i   (side_i),
    .insn_a_i (insn_a_i),
    .insn_b_i (insn_b_i),
    .fault_o  (beat_fault)
  );

  icp_way_seq #(.N_BEATS(N_BEATS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .beat_valid_i (beat_valid_i),
    .tag_fault_i  (tag_fault),
    .beat_fault_i (beat_fault),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .tag_err_o    (tag_err_o),
    .data_err_o   (data_err_o)
  );
endmodule

// File: rtl/icp_chk_sva.sv
module icp_chk_sva #(
  parameter int unsigned N_BEATS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic beat_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic tag_err_o,
  input logic data_err_o
);
  localparam int unsigned BC_W = $clog2(N_BEATS + 1);

  logic [BC_W-1:0] beats_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_seen <= '0;
    end else if (start_i && !busy_o) begin
      beats_seen <= '0;
    end else if (beat_valid_i && busy_o) begin
      beats_seen <= beats_seen + 1'b1;
    end
  end

  // R9: done lasts a single cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: done and busy never overlap
  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R9: done only after exactly N_BEATS accepted beats
  p_beat_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (beats_seen == BC_W'(N_BEATS)));

  // R8: accepted start clears the data flag and begins a way
  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !data_err_o && !done_o));

  // R8: the data flag is sticky within a way
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && data_err_o) |=> data_err_o);

  // R10: tag result unaffected while busy
  p_tag_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(tag_err_o));

  // R12: flags hold while idle without a start
  p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(tag_err_o) && $stable(data_err_o)));
endmodule

bind icache_parity_chk icp_chk_sva #(.N_BEATS(N_BEATS)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .beat_valid_i (beat_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .tag_err_o    (tag_err_o),
  .data_err_o   (data_err_o)
);

// File: tb/icache_parity_chk_tb.sv
module icache_parity_chk_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] tag_hi_i;
  logic [63:0] tag_lo_i;
  logic        beat_valid_i;
  logic [23:0] side_i;
  logic [31:0] insn_a_i;
  logic [31:0] insn_b_i;
  logic        busy_o, done_o, tag_err_o, data_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit ended   = 0;

  icache_parity_chk u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tag_hi_i(tag_hi_i),
    .tag_lo_i(tag_lo_i), .beat_valid_i(beat_valid_i), .side_i(side_i),
    .insn_a_i(insn_a_i), .insn_b_i(insn_b_i), .busy_o(busy_o),
    .done_o(done_o), .tag_err_o(tag_err_o), .data_err_o(data_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Tag table: {seed[31:0], valid, flip valid parity, flip bit10, flip bit11}
  localparam int NT = 9;
  localparam logic [35:0] TAG_TAB [NT] = '{
    {32'h1234_5678, 4'b1000}, {32'hDEAD_BEEF, 4'b0000},
    {32'h0F0F_3C3C, 4'b1100}, {32'h8001_0001, 4'b0100},
    {32'hCAFE_F00D, 4'b1010}, {32'h7777_0000, 4'b1001},
    {32'h0BAD_CAFE, 4'b0011}, {32'hFFFF_FFFF, 4'b1011},
    {32'h5555_AAAA, 4'b0111}
  };

  // Beat table: {seed[31:0], beat pos[1:0], flip predecode par, flip A[3:0], flip B[3:0]}
  localparam int NB = 10;
  localparam logic [42:0] BEAT_TAB [NB] = '{
    {32'h0000_0000, 2'd0, 1'b0, 4'h0, 4'h0}, {32'h1357_9BDF, 2'd2, 1'b0, 4'h0, 4'h0},
    {32'hA5A5_0F0F, 2'd0, 1'b1, 4'h0, 4'h0}, {32'h2468_ACE0, 2'd3, 1'b0, 4'h8, 4'h0},
    {32'h89AB_CDEF, 2'd1, 1'b0, 4'h1, 4'h0}, {32'hFEDC_BA98, 2'd2, 1'b0, 4'h0, 4'h8},
    {32'h0102_0408, 2'd3, 1'b0, 4'h0, 4'h1}, {32'h7F80_01FE, 2'd0, 1'b0, 4'h6, 4'h9},
    {32'h3C3C_C3C3, 2'd1, 1'b1, 4'hF, 4'hF}, {32'hFFFF_0000, 2'd3, 1'b0, 4'h0, 4'h0}
  };

  function automatic logic [3:0] byte_par(input logic [31:0] x);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = ^x[8*k +: 8];
    return r;
  endfunction

  function automatic logic [63:0] make_lo(input logic [31:0] s, input logic f0, input logic f1);
    logic [63:0] lo;
    lo = {s, s ^ 32'hA5C3_0F96};
    lo[10] = 1'b0;
    lo[11] = 1'b0;
    lo[10] = (^lo[23:0]) ^ f0;
    lo[11] = (^lo[63:24]) ^ f1;
    return lo;
  endfunction

  function automatic logic [31:0] make_hi(input logic [31:0] s, input logic v, input logic fv);
    logic [31:0] hi;
    hi = s;
    hi[29] = v;
    hi[27] = v ^ fv;
    return hi;
  endfunction

  // Clean or flipped beat; bits 23:17 filled from the seed (must be ignored)
  function automatic logic [87:0] make_beat(input logic [31:0] s, input logic fp,
                                            input logic [3:0] fa, input logic [3:0] fb);
    logic [31:0] a, b;
    logic [7:0]  pre;
    logic [23:0] side;
    a    = s;
    b    = {s[15:0], s[31:16]} ^ 32'h5A5A_C3C3;
    pre  = s[7:0] ^ 8'h96;
    side = {s[22:16], (^pre) ^ fp, pre, byte_par(a) ^ fa, byte_par(b) ^ fb};
    return {side, a, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic drive_idle();
    start_i      = 1'b0;
    beat_valid_i = 1'b0;
  endtask

  task automatic run_way(input logic [31:0] hi, input logic [63:0] lo,
                         input logic [3:0][87:0] beats, input bit gap,
                         input logic exp_t, input logic exp_d, input string req);
    @(negedge clk);
    start_i = 1'b1; tag_hi_i = hi; tag_lo_i = lo;
    @(negedge clk);
    start_i = 1'b0;
    tag_hi_i = ~hi;  // tag must have been sampled at start
    chk("R9 busy after start", {31'b0, busy_o}, 32'd1);
    for (int j = 0; j < 4; j++) begin
      if (gap && j == 2) begin
        beat_valid_i = 1'b0;
        @(negedge clk);
        chk("R9 busy during gap", {31'b0, busy_o}, 32'd1);
      end
      beat_valid_i = 1'b1;
      {side_i, insn_a_i, insn_b_i} = beats[j];
      @(negedge clk);
    end
    beat_valid_i = 1'b0;
    chk("R9 done pulse", {30'b0, busy_o, done_o}, 32'b01);
    chk({req, " tag flag"}, {31'b0, tag_err_o}, {31'b0, exp_t});
    chk({req, " data flag"}, {31'b0, data_err_o}, {31'b0, exp_d});
    @(negedge clk);
    chk("R9 done falls", {31'b0, done_o}, 32'd0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [3:0][87:0] bts;
    logic [31:0] chi;
    logic [63:0] clo;
    rst_n = 1'b0;
    drive_idle();
    tag_hi_i = '0; tag_lo_i = '0; side_i = '0; insn_a_i = '0; insn_b_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset outputs", {28'b0, busy_o, done_o, tag_err_o, data_err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after release", {28'b0, busy_o, done_o, tag_err_o, data_err_o}, 32'd0);

    for (int j = 0; j < 4; j++) bts[j] = make_beat(32'h1111_0000 * (j + 1), 1'b0, 4'h0, 4'h0);

    // Tag table walk: R1 R2 R3 R4
    for (int i = 0; i < NT; i++) begin
      logic v, fv, f0, f1;
      logic et;
      string rq;
      {v, fv, f0, f1} = TAG_TAB[i][3:0];
      et = fv | (v & (f0 | f1));
      if (fv) rq = "R1";
      else if (!v) rq = "R4";
      else if (f0) rq = "R2";
      else if (f1) rq = "R3";
      else rq = "R2";
      run_way(make_hi(TAG_TAB[i][35:4], v, fv), make_lo(TAG_TAB[i][35:4], f0, f1),
              bts, (i % 3) == 1, et, 1'b0, rq);
    end

    // Beat table walk: R5 R6 R7 R8
    chi = make_hi(32'h4242_4242, 1'b1, 1'b0);
    clo = make_lo(32'h4242_4242, 1'b0, 1'b0);
    for (int i = 0; i < NB; i++) begin
      logic [31:0] sd;
      logic [1:0]  pos;
      logic        fp;
      logic [3:0]  fa, fb;
      string       rq;
      {sd, pos, fp, fa, fb} = BEAT_TAB[i];
      for (int j = 0; j < 4; j++) begin
        if (j == pos) bts[j] = make_beat(sd, fp, fa, fb);
        else bts[j] = make_beat(sd ^ (32'h0101_0101 << j), 1'b0, 4'h0, 4'h0);
      end
      if (fp) rq = "R5";
      else if (fa != 0) rq = "R6";
      else if (fb != 0) rq = "R7";
      else rq = "R8";
      run_way(chi, clo, bts, (i % 2) == 0, 1'b0, fp | (|fa) | (|fb), rq);
    end

    // R8: error on first beat stays set through clean beats; next start clears it
    for (int j = 0; j < 4; j++) bts[j] = make_beat(32'h0F1E_2D3C + j, j == 0, 4'h0, 4'h0);
    run_way(chi, clo, bts, 1'b0, 1'b0, 1'b1, "R8 sticky");
    for (int j = 0; j < 4; j++) bts[j] = make_beat(32'h0F1E_2D3C + j, 1'b0, 4'h0, 4'h0);
    run_way(chi, clo, bts, 1'b0, 1'b0, 1'b0, "R8 cleared");

    // R12: after a faulty way, flags hold while idle
    for (int j = 0; j < 4; j++) bts[j] = make_beat(32'h7654_3210, 1'b0, 4'h2, 4'h0);
    run_way(make_hi(32'h1, 1'b0, 1'b1), clo, bts, 1'b0, 1'b1, 1'b1, "R12 setup");
    repeat (5) @(negedge clk);
    chk("R12 flags held", {30'b0, tag_err_o, data_err_o}, 32'b11);

    // R10: beat strobes while idle are ignored
    beat_valid_i = 1'b1;
    {side_i, insn_a_i, insn_b_i} = make_beat(32'h3, 1'b1, 4'h0, 4'h0);
    repeat (3) @(negedge clk);
    beat_valid_i = 1'b0;
    chk("R10 idle beats no busy/done", {30'b0, busy_o, done_o}, 32'd0);
    chk("R10 idle beats flags", {30'b0, tag_err_o, data_err_o}, 32'b11);

    // R10: start while busy is ignored (faulty tag offered mid-way)
    @(negedge clk);
    start_i = 1'b1; tag_hi_i = chi; tag_lo_i = clo;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < 4; j++) begin
      beat_valid_i = 1'b1;
      start_i = (j == 1);
      tag_hi_i = make_hi(32'h9, 1'b1, 1'b1);
      {side_i, insn_a_i, insn_b_i} = make_beat(32'hABCD_0000 + j, 1'b0, 4'h0, 4'h0);
      @(negedge clk);
    end
    start_i = 1'b0;
    beat_valid_i = 1'b0;
    chk("R10 start while busy ignored: done", {31'b0, done_o}, 32'd1);
    chk("R10 start while busy ignored: tag", {31'b0, tag_err_o}, 32'd0);
    @(negedge clk);
    chk("R10 no extra way started", {31'b0, busy_o}, 32'd0);

    // R11: reset mid-way
    @(negedge clk);
    start_i = 1'b1; tag_hi_i = make_hi(32'h5, 1'b1, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset mid-way", {28'b0, busy_o, done_o, tag_err_o, data_err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule